// File: doc/BRIEF.md
# Trace Message Queue Overflow Handler

This block is the message queue that sits between the trace sources of a debug unit and the serializer that sends trace traffic off chip. Three producers feed it: program trace, ownership trace and watchpoint. Each presents a valid strobe with a payload. The queue takes at most one message per cycle and gives the serializer the oldest message together with a kind code. The serializer acknowledges each message with a ready signal.

Sometimes traffic cannot be kept. This happens when a message meets a full queue, or when two or more sources present a message in the same cycle and only one can be written. The block then stops taking new messages and lets the serializer empty the queue. While the queue empties, the block records which message classes it turned away. When the queue is empty, it writes a single fixed-format error message in place of everything that was lost. The code inside that message summarises the lost classes. In the same step the block raises a one-cycle overrun pulse, so that the trace generator can force its next program trace message to carry full synchronisation.

Top module: `trace_ovf_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `overrun_pulse` are low and the queue holds no messages.
- R2: Accepted messages leave in arrival order, one per handshake (`out_valid` and `out_ready` both high). While `out_ready` is low, the head message and its kind stay unchanged. Kind codes: 0 program trace, 1 ownership trace, 2 watchpoint, 3 error.
- R3: When several sources present a message in the same cycle, one is written. Watchpoint wins over ownership trace, and ownership trace wins over program trace. Each losing message is lost and starts overflow handling.
- R4: A message that arrives while the queue holds `DEPTH` entries is lost and starts overflow handling. Filling the queue to exactly `DEPTH` entries loses nothing and produces no error message.
- R5: During overflow handling, every incoming message is discarded and its class is recorded. Messages already queued are still delivered in order.
- R6: In the cycle after the queue has become empty during overflow handling, exactly one error message is written. Its payload bits [5:0] are 6'b001000, bits [9:6] are the `SRC_ID` parameter, bits [14:10] are the error code, and all higher bits are zero.
- R7: Error code by lost classes: any watchpoint lost gives 5'b01000. Otherwise, ownership trace and program trace both lost gives 5'b00111. Ownership trace alone gives 5'b00010. Program trace alone gives 5'b00001.
- R8: `overrun_pulse` is high for exactly one cycle. That cycle is the first one in which the error message is at the head of the queue.
- R9: Writing the error message clears the record of lost classes. Messages that arrive in that same cycle are discarded without being recorded. Messages are accepted normally from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_valid | input | 1 | Program trace message strobe |
| pt_data | input | PAY_W | Program trace payload |
| ot_valid | input | 1 | Ownership trace message strobe |
| ot_data | input | PAY_W | Ownership trace payload |
| wp_valid | input | 1 | Watchpoint message strobe |
| wp_data | input | PAY_W | Watchpoint payload |
| out_valid | output | 1 | Head message is available |
| out_ready | input | 1 | Serializer takes the head message |
| out_kind | output | 2 | Kind code of the head message |
| out_data | output | PAY_W | Payload of the head message |
| overrun_pulse | output | 1 | One-cycle pulse when the error message enters the queue |

## Verification
The bench builds the block with `DEPTH` = 4, `PAY_W` = 16 and `SRC_ID` = 4'hA. A depth of four makes the full condition reachable in a few cycles. That lets a short table cover every error code, with losses both at the moment of overrun and later during the drain. The 16-bit payload leaves a zero bit above the error field, so the zero-extension of the error message is checked. The non-zero source ID shows that the ID field sits between the type code and the error code.

// File: rtl/trace_ovf_pkg.sv
package trace_ovf_pkg;

    // Producer index inside the per-source request vectors; a higher index wins.
    localparam int SRC_PROG  = 0;
    localparam int SRC_OWN   = 1;
    localparam int SRC_WATCH = 2;
    localparam int N_SRC     = 3;

    localparam int KIND_W    = 2;
    localparam int ERR_MSG_W = 15;

    typedef enum logic [KIND_W-1:0] {
        KIND_PROG  = 2'd0,
        KIND_OWN   = 2'd1,
        KIND_WATCH = 2'd2,
        KIND_ERR   = 2'd3
    } msg_kind_e;

    typedef enum logic {
        MODE_PASS  = 1'b0,
        MODE_DRAIN = 1'b1
    } ovf_mode_e;

    typedef logic [N_SRC-1:0] src_mask_t;

    localparam logic [5:0] ERR_TYPE_CODE = 6'b001000;

    localparam logic [4:0] CODE_PROG_ONLY = 5'b00001;
    localparam logic [4:0] CODE_OWN_ONLY  = 5'b00010;
    localparam logic [4:0] CODE_OWN_PROG  = 5'b00111;
    localparam logic [4:0] CODE_WATCH     = 5'b01000;

    // Summarise the set of lost classes into the error code.
    function automatic logic [4:0] lost_to_code(input src_mask_t lost);
        if (lost[SRC_WATCH])
            return CODE_WATCH;
        else if (lost[SRC_OWN] && lost[SRC_PROG])
            return CODE_OWN_PROG;
        else if (lost[SRC_OWN])
            return CODE_OWN_ONLY;
        else
            return CODE_PROG_ONLY;
    endfunction

endpackage

// File: rtl/trace_src_arb.sv
module trace_src_arb
    import trace_ovf_pkg::*;
#(
    parameter int PAY_W = 32
) (
    input  src_mask_t                    req,
    input  logic [N_SRC-1:0][PAY_W-1:0]  req_data,
    output logic                         win_valid,
    output msg_kind_e                    win_kind,
    output logic [PAY_W-1:0]             win_data,
    output src_mask_t                    lost
);

    src_mask_t grant;

    // Ascending scan: the last requester seen, i.e. the highest index, wins.
    always_comb begin
        win_valid = 1'b0;
        win_kind  = KIND_PROG;
        win_data  = '0;
        grant     = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i]) begin
                win_valid = 1'b1;
                win_kind  = msg_kind_e'(i);
                win_data  = req_data[i];
                grant     = '0;
                grant[i]  = 1'b1;
            end
        end
        lost = req & ~grant;
    end

endmodule

// File: rtl/trace_msg_fifo.sv
module trace_msg_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 34,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/trace_ovf_ctrl.sv
module trace_ovf_ctrl
    import trace_ovf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_mask_t  req,
    input  src_mask_t  lost,
    input  logic       win_valid,
    input  logic       q_full,
    input  logic       q_empty,
    output logic       push_msg,
    output logic       push_err,
    output logic [4:0] err_code,
    output logic       overrun_pulse
);

    ovf_mode_e mode_q, mode_d;
    src_mask_t dropped_q, dropped_d;

    always_comb begin
        push_msg  = 1'b0;
        push_err  = 1'b0;
        mode_d    = mode_q;
        dropped_d = dropped_q;
        unique case (mode_q)
            MODE_PASS: begin
                if (win_valid) begin
                    if (q_full) begin
                        // Nothing fits: every strobe this cycle is lost.
                        dropped_d = dropped_q | req;
                        mode_d    = MODE_DRAIN;
                    end else begin
                        push_msg = 1'b1;
                        if (|lost) begin
                            dropped_d = dropped_q | lost;
                            mode_d    = MODE_DRAIN;
                        end
                    end
                end
            end
            MODE_DRAIN: begin
                if (q_empty) begin
                    // Queue fully drained: insert the summary, arrivals now are not logged.
                    push_err  = 1'b1;
                    dropped_d = '0;
                    mode_d    = MODE_PASS;
                end else begin
                    dropped_d = dropped_q | req;
                end
            end
            default: mode_d = MODE_PASS;
        endcase
    end

    assign err_code = lost_to_code(dropped_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q        <= MODE_PASS;
            dropped_q     <= '0;
            overrun_pulse <= 1'b0;
        end else begin
            mode_q        <= mode_d;
            dropped_q     <= dropped_d;
            overrun_pulse <= push_err;
        end
    end

endmodule

// File: rtl/trace_ovf_queue.sv
module trace_ovf_queue
    import trace_ovf_pkg::*;
#(
    parameter int         DEPTH  = 8,
    parameter int         PAY_W  = 32,
    parameter logic [3:0] SRC_ID = 4'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pt_valid,
    input  logic [PAY_W-1:0] pt_data,
    input  logic             ot_valid,
    input  logic [PAY_W-1:0] ot_data,
    input  logic             wp_valid,
    input  logic [PAY_W-1:0] wp_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_kind,
    output logic [PAY_W-1:0] out_data,
    output logic             overrun_pulse
);

    // PAY_W must be at least ERR_MSG_W so the error message fits in a payload.
    localparam int ENTRY_W = KIND_W + PAY_W;
    localparam int CW      = $clog2(DEPTH + 1);

    src_mask_t                   req;
    logic [N_SRC-1:0][PAY_W-1:0] req_data;
    logic                        win_valid;
    msg_kind_e                   win_kind;
    logic [PAY_W-1:0]            win_data;
    src_mask_t                   lost;

    logic                        push_msg;
    logic                        push_err;
    logic [4:0]                  err_code;
    logic [PAY_W-1:0]            err_payload;

    logic                        q_push;
    logic [ENTRY_W-1:0]          q_wdata;
    logic [ENTRY_W-1:0]          q_head;
    logic [CW-1:0]               fill_cnt;
    logic                        q_empty;
    logic                        q_full;

    always_comb begin
        req                 = '0;
        req[SRC_PROG]       = pt_valid;
        req[SRC_OWN]        = ot_valid;
        req[SRC_WATCH]      = wp_valid;
        req_data            = '0;
        req_data[SRC_PROG]  = pt_data;
        req_data[SRC_OWN]   = ot_data;
        req_data[SRC_WATCH] = wp_data;
    end

    trace_src_arb #(
        .PAY_W (PAY_W)
    ) i_arb (
        .req       (req),
        .req_data  (req_data),
        .win_valid (win_valid),
        .win_kind  (win_kind),
        .win_data  (win_data),
        .lost      (lost)
    );

    trace_ovf_ctrl i_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req           (req),
        .lost          (lost),
        .win_valid     (win_valid),
        .q_full        (q_full),
        .q_empty       (q_empty),
        .push_msg      (push_msg),
        .push_err      (push_err),
        .err_code      (err_code),
        .overrun_pulse (overrun_pulse)
    );

    always_comb begin
        err_payload = '0;
        err_payload[ERR_MSG_W-1:0] = {err_code, SRC_ID, ERR_TYPE_CODE};
    end

    assign q_push  = push_msg || push_err;
    assign q_wdata = push_err ? {KIND_ERR, err_payload} : {win_kind, win_data};

    trace_msg_fifo #(
        .DEPTH (DEPTH),
        .W     (ENTRY_W)
    ) i_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (q_wdata),
        .pop       (out_valid && out_ready),
        .head      (q_head),
        .count     (fill_cnt),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign out_valid = !q_empty;
    assign out_kind  = q_head[ENTRY_W-1 -: KIND_W];
    assign out_data  = q_head[PAY_W-1:0];

endmodule

// File: rtl/trace_ovf_queue_chk.sv
module trace_ovf_queue_chk #(
    parameter int         DEPTH  = 8,
    parameter int         PAY_W  = 32,
    parameter logic [3:0] SRC_ID = 4'h0,
    localparam int        CW     = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_kind,
    input logic [PAY_W-1:0] out_data,
    input logic             overrun_pulse,
    input logic [CW-1:0]    fill
);

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_data)));

    // R6
    err_format_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd3) |->
            (out_data[9:0] == {SRC_ID, 6'b001000} && (out_data >> 15) == '0));

    // R7
    err_code_set_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd3) |->
            (out_data[14:10] == 5'b00001 || out_data[14:10] == 5'b00010 ||
             out_data[14:10] == 5'b00111 || out_data[14:10] == 5'b01000));

    // R8
    pulse_heads_queue_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_pulse |-> (out_valid && out_kind == 2'd3));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_pulse |=> !overrun_pulse);

endmodule

bind trace_ovf_queue trace_ovf_queue_chk #(
    .DEPTH  (DEPTH),
    .PAY_W  (PAY_W),
    .SRC_ID (SRC_ID)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_kind      (out_kind),
    .out_data      (out_data),
    .overrun_pulse (overrun_pulse),
    .fill          (fill_cnt)
);

// File: tb/test_trace_ovf_queue.sv
module test_trace_ovf_queue;

    localparam int         DEPTH  = 4;
    localparam int         PAY_W  = 16;
    localparam logic [3:0] SRC_ID = 4'hA;

    logic             clk = 1'b0;
    logic             rst;
    logic             pt_valid, ot_valid, wp_valid;
    logic [PAY_W-1:0] pt_data, ot_data, wp_data;
    logic             out_valid;
    logic             out_ready;
    logic [1:0]       out_kind;
    logic [PAY_W-1:0] out_data;
    logic             overrun_pulse;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    trace_ovf_queue #(
        .DEPTH  (DEPTH),
        .PAY_W  (PAY_W),
        .SRC_ID (SRC_ID)
    ) i_trace_ovf_queue (
        .clk           (clk),
        .rst           (rst),
        .pt_valid      (pt_valid),
        .pt_data       (pt_data),
        .ot_valid      (ot_valid),
        .ot_data       (ot_data),
        .wp_valid      (wp_valid),
        .wp_data       (wp_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_kind      (out_kind),
        .out_data      (out_data),
        .overrun_pulse (overrun_pulse)
    );

    // Scenario table: {mask lost at overrun, mask sent during drain, expected code}.
    // Mask bit 0 program trace, bit 1 ownership trace, bit 2 watchpoint.
    localparam logic [10:0] VEC [6] = '{
        {3'b001, 3'b000, 5'b00001},
        {3'b010, 3'b000, 5'b00010},
        {3'b001, 3'b010, 5'b00111},
        {3'b100, 3'b000, 5'b01000},
        {3'b010, 3'b101, 5'b01000},
        {3'b011, 3'b000, 5'b00111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setsrc(input logic [2:0] m, input logic [PAY_W-1:0] d);
        pt_valid = m[0];
        ot_valid = m[1];
        wp_valid = m[2];
        pt_data  = d;
        ot_data  = d ^ 16'h1000;
        wp_data  = d ^ 16'h2000;
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        out_ready = 1'b0;
        setsrc(3'b000, '0);
        repeat (3) step();
        rst = 1'b0;
    endtask

    function automatic logic [PAY_W-1:0] err_word(input logic [4:0] code);
        return {1'b0, code, SRC_ID, 6'b001000};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 pulse", 32'(overrun_pulse), 0);
        step();
        chk("R1 still empty", 32'(out_valid), 0);

        // R4 R5 R6 R7 R8: table-driven overflow scenarios
        for (int v = 0; v < 6; v++) begin
            do_reset();
            for (int i = 0; i < DEPTH; i++) begin
                setsrc(3'b001, PAY_W'(16'h0100 + i));
                step();
            end
            setsrc(VEC[v][10:8], 16'hDEAD);
            step();
            setsrc(VEC[v][7:5], 16'hBEEF);
            step();
            setsrc(3'b000, '0);
            out_ready = 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                chk("R5 queued kind", {30'd0, out_kind}, 0);
                chk("R5 queued data", 32'(out_data), 32'h0100 + 32'(i));
                step();
            end
            out_ready = 1'b0;
            chk("R6 empty before insert", 32'(out_valid), 0);
            step();
            chk("R8 pulse", 32'(overrun_pulse), 1);
            chk("R6 err kind", {30'd0, out_kind}, 3);
            chk("R7 err word", 32'(out_data), 32'(err_word(VEC[v][4:0])));
            step();
            chk("R8 pulse one cycle", 32'(overrun_pulse), 0);
            chk("R6 err held", {30'd0, out_kind}, 3);
            out_ready = 1'b1;
            step();
            out_ready = 1'b0;
            chk("R6 single error", 32'(out_valid), 0);
        end

        // R4 boundary: exactly DEPTH messages lose nothing
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            setsrc(3'b010, PAY_W'(16'h0040 + i));
            step();
        end
        setsrc(3'b000, '0);
        out_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R4 kind", {30'd0, out_kind}, 1);
            chk("R4 data", 32'(out_data), 32'h1040 + 32'(i));
            step();
        end
        out_ready = 1'b0;
        repeat (3) step();
        chk("R4 no error", 32'(out_valid), 0);
        chk("R4 no pulse", 32'(overrun_pulse), 0);

        // R2 ordering of mixed kinds
        do_reset();
        setsrc(3'b010, 16'h0010); step();
        setsrc(3'b100, 16'h0020); step();
        setsrc(3'b001, 16'h0030); step();
        setsrc(3'b000, '0);
        step();
        chk("R2 head held kind", {30'd0, out_kind}, 1);
        out_ready = 1'b1;
        chk("R2 first", 32'(out_data), 32'h1010);
        step();
        chk("R2 second kind", {30'd0, out_kind}, 2);
        chk("R2 second", 32'(out_data), 32'h2020);
        step();
        chk("R2 third kind", {30'd0, out_kind}, 0);
        chk("R2 third", 32'(out_data), 32'h0030);
        step();
        out_ready = 1'b0;
        chk("R2 drained", 32'(out_valid), 0);

        // R3 collision on an empty queue, then R9 resume
        do_reset();
        setsrc(3'b101, 16'h0077);
        step();
        setsrc(3'b000, '0);
        chk("R3 winner kind", {30'd0, out_kind}, 2);
        chk("R3 winner data", 32'(out_data), 32'h2077);
        step();
        chk("R2 hold while not ready", 32'(out_data), 32'h2077);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        setsrc(3'b001, 16'h0033);
        chk("R3 drained", 32'(out_valid), 0);
        step();
        setsrc(3'b001, 16'h0055);
        chk("R3 pulse", 32'(overrun_pulse), 1);
        chk("R3 lost program code", 32'(out_data), 32'(err_word(5'b00001)));
        step();
        setsrc(3'b000, '0);
        chk("R9 error at head", {30'd0, out_kind}, 3);
        out_ready = 1'b1;
        step();
        chk("R9 resumed kind", {30'd0, out_kind}, 0);
        chk("R9 resumed data", 32'(out_data), 32'h0055);
        step();
        out_ready = 1'b0;
        chk("R9 insert-cycle message discarded", 32'(out_valid), 0);
        repeat (2) step();
        chk("R9 no second error", 32'(out_valid), 0);
        chk("R9 no second pulse", 32'(overrun_pulse), 0);

        finish_run();
    end

endmodule